// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Capture

This block is a memory-mapped bank of general-purpose pins, up to 32 of them. A simple register bus carries an address, a write strobe, write data and combinational read data. Software uses it to drive pad output values and output enables, to read the pad inputs, and to configure how each pin raises an interrupt. Bit n of every register belongs to pin n.

Each pin has its own trigger selection. It can detect a level (high or low) or an edge (rising, falling or both). Detected events are stored in a capture register, and software clears that register by writing ones. A per-pin enable masks each captured bit. The enabled bits are merged into one interrupt line for the rest of the chip. The output, direction and enable registers also have write-one-to-set and write-one-to-clear aliases, so software can change a single pin without a read-modify-write.

Pad inputs are brought into the clock domain through a two-flop synchronizer. One more stored flop holds the previous synchronized value, and edge detection compares against it.

Top module: `pinbank_irq`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. This means `pad_oe` = 0, `pad_out` = 0, all interrupts are disabled, the capture register is empty and `irq` = 0.
- R2: The direction register at byte offset 0x08 is read/write, and a bit of 1 makes that pin an output; `pad_oe` equals this register. Writing ones to offset 0x14 sets those direction bits, and writing ones to offset 0x18 clears them. Zero bits in the written data leave the pin unchanged.
- R3: The output register at offset 0x00 is read/write and drives `pad_out`. Writing ones to offset 0x0C sets those bits, and writing ones to offset 0x10 clears them. Zero bits leave the pin unchanged.
- R4: Offset 0x04 reads the pad inputs after a two-flop synchronizer. Writes to this offset have no effect.
- R5: The alias offsets 0x0C, 0x10, 0x14, 0x18 and 0x34 always read as 0.
- R6: A bit of 0 in the mode register (offset 0x20) selects edge detection for that pin. In edge mode, when the both-edges bit (offset 0x28) is 0 and the polarity bit (offset 0x24) is 0, only a rising edge sets the pin's capture bit.
- R7: In edge mode, when the both-edges bit is 0 and the polarity bit is 1, only a falling edge sets the capture bit.
- R8: In edge mode, a both-edges bit of 1 makes rising and falling edges both set the capture bit, whatever the polarity bit holds.
- R9: The capture register at offset 0x2C holds edge events until software clears them. Writing ones clears those bits, and zero bits have no effect.
- R10: A mode bit of 1 selects level detection. Polarity 0 means the pin is active when high, and polarity 1 means active when low. While the level is active, the capture bit is set on every cycle. When a set and a clear of the same bit happen in one cycle, the set wins.
- R11: Writing ones to offset 0x30 sets interrupt enables, and writing ones to offset 0x34 clears them; the enables read back at 0x30. The output `irq` is 1 exactly when some pin has both its capture bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_out | output | NUM_PINS | Output value for each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check four things:
- the set and clear aliases for direction and output act only on the bits written with one;
- the alias offsets read as zero;
- a captured bit never drops unless a capture write happens;
- `irq` stays low while no enable is set.

The trigger modes depend on pad history, so only the bench's scenarios can show them. Those scenarios cover rising-only, falling-only, both-edges, level-high with a clear that loses against an active level, and level-low. The bench also checks the synchronizer latency seen at the input register, and that clearing an enable masks `irq` while the capture bit stays set.

// File: rtl/pinbank_pkg.sv
// Package: shared constants for the pin bank.
// Holds the bus widths and the byte offsets of every register.
package pinbank_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_OUT      = 8'h00;
    localparam logic [ADDR_W-1:0] A_IN       = 8'h04;
    localparam logic [ADDR_W-1:0] A_DIR      = 8'h08;
    localparam logic [ADDR_W-1:0] A_OUT_SET  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_OUT_CLR  = 8'h10;
    localparam logic [ADDR_W-1:0] A_DIR_SET  = 8'h14;
    localparam logic [ADDR_W-1:0] A_DIR_CLR  = 8'h18;
    localparam logic [ADDR_W-1:0] A_MODE     = 8'h20;
    localparam logic [ADDR_W-1:0] A_POL      = 8'h24;
    localparam logic [ADDR_W-1:0] A_BOTH     = 8'h28;
    localparam logic [ADDR_W-1:0] A_CAP      = 8'h2C;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 8'h30;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 8'h34;
endpackage

// File: rtl/pinbank_sync.sv
// Module: pad input synchronizer.
// Passes each pad through a chain of STAGES flops and also keeps the
// previous synchronized value, which edge detection compares against.
// Assumes the pads are asynchronous to clk. Reset is synchronous and
// active-low.
module pinbank_sync #(
    parameter int NUM_PINS = 32,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] sync_o,
    output logic [NUM_PINS-1:0] prev_o
);
    logic [NUM_PINS-1:0] stage_q [STAGES];
    logic [NUM_PINS-1:0] prev_q;

    // Shift the pad values through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= pad_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Keep the last synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/pinbank_detect.sv
// Module: per-pin event detector.
// Combinational. For each pin it raises hit_o when the trigger chosen by
// mode (1 = level), pol (1 = low/falling) and both (edge mode only) is met.
// Assumes cur and prev are synchronized values one cycle apart.
module pinbank_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] cur,
    input  logic [NUM_PINS-1:0] prev,
    input  logic [NUM_PINS-1:0] mode,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] both,
    output logic [NUM_PINS-1:0] hit_o
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic level_hit;
        logic rise;
        logic fall;
        logic edge_hit;

        // Work out the level and edge conditions for this pin.
        always_comb begin
            level_hit = cur[g] ^ pol[g];
            rise      = cur[g] & ~prev[g];
            fall      = ~cur[g] & prev[g];
            if (both[g])     edge_hit = rise | fall;
            else if (pol[g]) edge_hit = fall;
            else             edge_hit = rise;
        end

        assign hit_o[g] = mode[g] ? level_hit : edge_hit;
    end
endmodule

// File: rtl/pinbank_irq.sv
// Module: GPIO bank top. Holds the register file, the aliased set and
// clear writes, the capture register and the combined interrupt line.
// Assumes one write per bus_we cycle and a read address that is held
// while bus_rdata is sampled. Reset is synchronous and active-low.
module pinbank_irq
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic                irq
);
    logic [NUM_PINS-1:0] out_q, dir_q, mode_q, pol_q, both_q, cap_q, en_q;
    logic [NUM_PINS-1:0] sync_v, prev_v, hit;
    logic [NUM_PINS-1:0] wmask;
    logic [NUM_PINS-1:0] cap_clr;

    assign wmask = bus_wdata[NUM_PINS-1:0];

    pinbank_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    pinbank_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .cur   (sync_v),
        .prev  (prev_v),
        .mode  (mode_q),
        .pol   (pol_q),
        .both  (both_q),
        .hit_o (hit)
    );

    // Output value register with its set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)                              out_q <= '0;
        else if (bus_we && bus_addr == A_OUT)     out_q <= wmask;
        else if (bus_we && bus_addr == A_OUT_SET) out_q <= out_q | wmask;
        else if (bus_we && bus_addr == A_OUT_CLR) out_q <= out_q & ~wmask;
    end

    // Direction register with its set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)                              dir_q <= '0;
        else if (bus_we && bus_addr == A_DIR)     dir_q <= wmask;
        else if (bus_we && bus_addr == A_DIR_SET) dir_q <= dir_q | wmask;
        else if (bus_we && bus_addr == A_DIR_CLR) dir_q <= dir_q & ~wmask;
    end

    // Trigger configuration registers, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_MODE) mode_q <= wmask;
            if (bus_addr == A_POL)  pol_q  <= wmask;
            if (bus_addr == A_BOTH) both_q <= wmask;
        end
    end

    // Interrupt enables, changed only through the set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)                             en_q <= '0;
        else if (bus_we && bus_addr == A_EN_SET) en_q <= en_q | wmask;
        else if (bus_we && bus_addr == A_EN_CLR) en_q <= en_q & ~wmask;
    end

    // Capture register: a new event wins over a clear in the same cycle.
    assign cap_clr = (bus_we && bus_addr == A_CAP) ? wmask : '0;
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~cap_clr) | hit;
    end

    // Read mux; the aliases and unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            A_OUT:    bus_rdata = DATA_W'(out_q);
            A_IN:     bus_rdata = DATA_W'(sync_v);
            A_DIR:    bus_rdata = DATA_W'(dir_q);
            A_MODE:   bus_rdata = DATA_W'(mode_q);
            A_POL:    bus_rdata = DATA_W'(pol_q);
            A_BOTH:   bus_rdata = DATA_W'(both_q);
            A_CAP:    bus_rdata = DATA_W'(cap_q);
            A_EN_SET: bus_rdata = DATA_W'(en_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
    assign irq     = |(cap_q & en_q);
endmodule

// File: rtl/pinbank_irq_chk.sv
// Module: assertion checker for pinbank_irq, attached by bind.
// Watches the bus, the pad controls and the capture and enable state.
module pinbank_irq_chk
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] cap_q,
    input logic [NUM_PINS-1:0] en_q,
    input logic                irq
);
    p_dirset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR_SET) |=>
        ((pad_oe & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

    p_dirclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR_CLR) |=>
        ((pad_oe & $past(bus_wdata[NUM_PINS-1:0])) == '0));

    p_outset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_OUT_SET) |=>
        ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

    p_outclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_OUT_CLR) |=>
        ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == '0));

    p_alias_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_OUT_SET || bus_addr == A_OUT_CLR || bus_addr == A_DIR_SET ||
         bus_addr == A_DIR_CLR || bus_addr == A_EN_CLR) |-> (bus_rdata == '0));

    p_cap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_CAP) |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

bind pinbank_irq pinbank_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .cap_q     (cap_q),
    .en_q      (en_q),
    .irq       (irq)
);

// File: tb/pinbank_irq_test.sv
// Directed bench for pinbank_irq: one task per scenario, each checking
// its own results against values derived from the requirements.
module pinbank_irq_test;
    import pinbank_pkg::*;
    localparam int CLK_P = 10;
    localparam int N     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [N-1:0]      pad_out, pad_oe;
    logic [N-1:0]      pad_in = '0;
    logic              irq;
    int                total = 0;
    int                bad = 0;
    bit                done = 1'b0;

    pinbank_irq #(.NUM_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_in(pad_in), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_OUT, v);  chk("R1 out", v, 0);
        rd(A_DIR, v);  chk("R1 dir", v, 0);
        rd(A_CAP, v);  chk("R1 cap", v, 0);
        rd(A_EN_SET, v); chk("R1 en", v, 0);
        rd(A_MODE, v); chk("R1 mode", v, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_out", pad_out, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_dir_out();
        logic [31:0] v;
        wr(A_DIR_SET, 32'h0000_000F);
        wr(A_DIR_CLR, 32'h0000_0003);
        rd(A_DIR, v); chk("R2 dir after set/clr", v, 32'h0000_000C);
        chk("R2 pad_oe", pad_oe, 32'h0000_000C);
        wr(A_DIR, 32'h8000_0001);
        chk("R2 dir direct", pad_oe, 32'h8000_0001);
        wr(A_OUT, 32'h1234_5678);
        chk("R3 out direct", pad_out, 32'h1234_5678);
        wr(A_OUT_SET, 32'h8000_0001);
        wr(A_OUT_CLR, 32'h0000_0070);
        rd(A_OUT, v); chk("R3 out after set/clr", v, 32'h9234_5609);
        chk("R3 pad_out", pad_out, 32'h9234_5609);
        rd(A_OUT_SET, v); chk("R5 out_set reads 0", v, 0);
        rd(A_OUT_CLR, v); chk("R5 out_clr reads 0", v, 0);
        rd(A_DIR_SET, v); chk("R5 dir_set reads 0", v, 0);
        rd(A_DIR_CLR, v); chk("R5 dir_clr reads 0", v, 0);
        rd(A_EN_CLR, v);  chk("R5 en_clr reads 0", v, 0);
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 32'hA5A5_0000;
        @(negedge clk);
        bus_addr = A_IN;
        #1 chk("R4 one cycle not yet visible", bus_rdata, 0);
        @(negedge clk);
        #1 chk("R4 visible after two flops", bus_rdata, 32'hA5A5_0000);
        wr(A_IN, 32'hFFFF_FFFF);
        rd(A_IN, v); chk("R4 write ignored", v, 32'hA5A5_0000);
        pad_in = '0;
        settle();
        wr(A_CAP, 32'hFFFF_FFFF);
        rd(A_CAP, v); chk("R9 clear all", v, 0);
    endtask

    task automatic t_rising();
        logic [31:0] v;
        wr(A_EN_SET, 32'h1);
        pad_in[0] = 1'b1; settle();
        rd(A_CAP, v); chk("R6 rising captured", v, 32'h1);
        chk("R11 irq on", {31'b0, irq}, 1);
        pad_in[0] = 1'b0; settle();
        rd(A_CAP, v); chk("R9 sticky after fall", v, 32'h1);
        wr(A_CAP, 32'h0);
        rd(A_CAP, v); chk("R9 zero write no effect", v, 32'h1);
        wr(A_CAP, 32'h1);
        rd(A_CAP, v); chk("R6 fall not captured", v, 0);
        chk("R11 irq off", {31'b0, irq}, 0);
    endtask

    task automatic t_falling();
        logic [31:0] v;
        wr(A_POL, 32'h2);
        pad_in[1] = 1'b1; settle();
        rd(A_CAP, v); chk("R7 rise ignored", v, 0);
        pad_in[1] = 1'b0; settle();
        rd(A_CAP, v); chk("R7 falling captured", v, 32'h2);
        wr(A_CAP, 32'h2);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(A_BOTH, 32'h4);
        pad_in[2] = 1'b1; settle();
        rd(A_CAP, v); chk("R8 rise captured", v, 32'h4);
        wr(A_CAP, 32'h4);
        rd(A_CAP, v); chk("R9 cleared", v, 0);
        pad_in[2] = 1'b0; settle();
        rd(A_CAP, v); chk("R8 fall captured", v, 32'h4);
        wr(A_EN_SET, 32'h4);
        chk("R11 irq from pin2", {31'b0, irq}, 1);
        wr(A_EN_CLR, 32'h4);
        chk("R11 irq masked", {31'b0, irq}, 0);
        rd(A_CAP, v); chk("R11 cap kept when masked", v, 32'h4);
        rd(A_EN_SET, v); chk("R11 enable readback", v, 32'h1);
        wr(A_CAP, 32'h4);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(A_MODE, 32'h30);
        pad_in[4] = 1'b1; settle();
        rd(A_CAP, v); chk("R10 level high captured", v, 32'h10);
        wr(A_CAP, 32'h10);
        rd(A_CAP, v); chk("R10 set wins over clear", v, 32'h10);
        pad_in[4] = 1'b0; settle();
        wr(A_CAP, 32'h10);
        rd(A_CAP, v); chk("R10 clear holds when inactive", v, 0);
        wr(A_POL, 32'h22);
        @(negedge clk);
        rd(A_CAP, v); chk("R10 level low captured", v, 32'h20);
        pad_in[5] = 1'b1; settle();
        wr(A_CAP, 32'h20);
        rd(A_CAP, v); chk("R10 level low cleared", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir_out();
        t_input();
        t_rising();
        t_falling();
        t_both();
        t_level();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule